// File: doc/BRIEF.md
# Byte Permute with Sign Replication

This datapath unit forms one 32-bit result word from four bytes chosen out of an eight-byte pool. The pool is made of two 32-bit source words. A control word holds one 4-bit selector for each result byte. The low three bits of a selector name the pool byte to copy. Its top bit makes the result byte either that byte unchanged or eight copies of that byte's most significant bit. A single operation therefore does both the byte shuffle and a per-byte sign fill.

The unit takes an input-valid strobe with each operand set and returns an output-valid strobe with the result. A parameter picks one of two builds. In the first, the result leaves through one output register with one cycle of latency. In the second, the path is purely combinational. The control port may be wider than 16 bits so that it can hang off a wider control bus. Only its low 16 bits take part in the operation.

Top module: `byte_shuffle_signfill`

## Requirements
- R1: Result byte i, for i = 0 to 3 with byte 0 as bits [7:0], is governed by the selector in control bits [4i+3:4i].
- R2: Selector bits [2:0] give a pool index from 0 to 7. Indices 0 to 3 pick bytes 0 to 3 of `src_a`, least significant byte first. Indices 4 to 7 pick bytes 0 to 3 of `src_b`.
- R3: When selector bit 3 is 1, the result byte is 0xFF if bit 7 of the picked byte is 1, and 0x00 if it is 0.
- R4: Each result byte is decided by its own selector alone. A selector with bit 3 at 0 passes its picked byte through unchanged, whatever the other lanes do.
- R5: With `src_a` = 0x70C507D6, `src_b` = 0x6FBD4B5C and control 0x7604, the result is 0x6FBDD65C.
- R6: With the same sources and control 0x7E0C, the result is 0x6FFFD600.
- R7: Control bits above bit 15 have no effect on the result.
- R8: In the registered build (REGISTERED=1), `out_valid` equals the `in_valid` of the previous clock edge. Whenever `out_valid` is 1, `result` is the function of the operands sampled at that edge.
- R9: In the registered build, `result` keeps its value across edges where `in_valid` is 0.
- R10: While `rst_n` is low, the registered build holds `result` at 0 and `out_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the registered build) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and control are valid this cycle |
| src_a | input | 32 | First source word, pool indices 0 to 3 |
| src_b | input | 32 | Second source word, pool indices 4 to 7 |
| ctrl | input | CTRL_W | Four selectors in bits [15:0]; higher bits unused |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Permuted and sign-filled word |

## Verification
The bench steps each lane through all sixteen selector values against operands that hold bytes with bit 7 both set and clear in both sources. A design that mixed up the source order or the byte order would put the wrong byte in a lane. A design that took the fill bit from the wrong place would fill with the sign of bit 0, or of the unshuffled byte. The bench also checks two directed control values and uses pairs of control words that differ only above bit 15. A design that decoded the upper bits would change its result on these pairs. In hold and reset windows it checks that a registered result is neither overwritten by idle cycles nor left dirty after reset.

// File: rtl/byte_shuffle_signfill.sv
module byte_shuffle_signfill #(
  parameter int CTRL_W     = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       src_a,
  input  logic [31:0]       src_b,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              out_valid,
  output logic [31:0]       result
);

  localparam int LANES = 4;
  localparam int SEL_W = 4;

  logic [63:0] pool;
  logic [31:0] shuffled;

  assign pool = {src_b, src_a};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    logic [7:0]       picked;
    assign sel    = ctrl[SEL_W*i +: SEL_W];
    assign picked = pool[8*sel[2:0] +: 8];
    assign shuffled[8*i +: 8] = sel[3] ? {8{picked[7]}} : picked;
  end

  if (REGISTERED) begin : g_reg
    logic [31:0] res_q;
    logic        vld_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) res_q <= shuffled;
      end
    end

    assign result    = res_q;
    assign out_valid = vld_q;

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && $past(rst_n)) |=> $stable(result));
    a_r2_lane0_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctrl[3:0] == 4'h0) |=> result[7:0] == $past(src_a[7:0]));

    for (genvar k = 0; k < LANES; k++) begin : g_fill_chk
      a_r3_fill_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[SEL_W*k+3]) |=>
          (result[8*k +: 8] == 8'h00 || result[8*k +: 8] == 8'hFF));
    end
  end else begin : g_comb
    assign result    = shuffled;
    assign out_valid = in_valid;

    a_r8_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
    a_r3_comb_fill: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[3] |-> (result[7:0] == 8'h00 || result[7:0] == 8'hFF));
    a_r2_comb_pass: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[3:0] == 4'h4 |-> result[7:0] == src_b[7:0]);
    a_r4_comb_lane3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[15:12] == 4'h3 |-> result[31:24] == src_a[31:24]);
  end

endmodule

// File: tb/byte_shuffle_signfill_test.sv
`timescale 1ns/1ps
module byte_shuffle_signfill_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] ctrl = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  byte_shuffle_signfill #(.CTRL_W(32), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
    .src_b(src_b), .ctrl(ctrl), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] c);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] s;
      logic [7:0] byt;
      s = c[4*i +: 4];
      if (s[2]) byt = b[8*s[1:0] +: 8];
      else      byt = a[8*s[1:0] +: 8];
      r[8*i +: 8] = s[3] ? (byt[7] ? 8'hFF : 8'h00) : byt;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    src_a = a; src_b = b; ctrl = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 result in reset", result, 32'h0);
    check("R10 out_valid in reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_examples;
    apply(32'h70C507D6, 32'h6FBD4B5C, 32'h7604);
    check("R5 example", result, 32'h6FBDD65C);
    check("R8 valid", {31'b0, out_valid}, 32'h1);
    apply(32'h70C507D6, 32'h6FBD4B5C, 32'h7E0C);
    check("R6 example", result, 32'h6FFFD600);
  endtask

  task automatic t_sweep;
    logic [31:0] a = 32'h70C507D6;
    logic [31:0] b = 32'h6FBD4B5C;
    for (int lane = 0; lane < 4; lane++) begin
      for (int s = 0; s < 16; s++) begin
        logic [15:0] c;
        c = 16'h3210;
        c[4*lane +: 4] = s[3:0];
        apply(a, b, {16'h0, c});
        check($sformatf("R1 R2 R3 R4 lane%0d sel%0h", lane, s), result, model(a, b, c));
      end
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      apply(a, b, c);
      check("R4 random", result, model(a, b, c[15:0]));
    end
  endtask

  task automatic t_upper_ignored;
    apply(32'h80FF017F, 32'h11C2E300, 32'hFFFF_9AC5);
    check("R7 upper ones", result, model(32'h80FF017F, 32'h11C2E300, 16'h9AC5));
    apply(32'h80FF017F, 32'h11C2E300, 32'h5A5A_9AC5);
    check("R7 upper mixed", result, model(32'h80FF017F, 32'h11C2E300, 16'h9AC5));
  endtask

  task automatic t_hold;
    logic [31:0] held;
    apply(32'h70C507D6, 32'h6FBD4B5C, 32'h7604);
    held = result;
    src_a = 32'hDEADBEEF; src_b = 32'h01234567; ctrl = 32'hCCCC;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 hold", result, held);
      check("R8 idle valid", {31'b0, out_valid}, 32'h0);
    end
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 result after reset", result, 32'h0);
    check("R10 valid after reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_examples();
    t_sweep();
    t_random();
    t_upper_ignored();
    t_hold();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule